// File: doc/BRIEF.md
# Framed 8b10b Serial Line Transmitter

This block sends an endless stream of frames over one serial line. Each frame starts with the K28.1 comma character and then carries `NBYTES` data bytes taken from a small payload array. Every symbol is 8b10b coded with running-disparity tracking, kept in a one-deep holding register, and then moved into an 11-bit shifter. The shifter sends one bit per bit period. The bit period is `PRESCALE * PERIOD` clocks: a prescaler makes a time-base tick, and a period counter counts those ticks. The line leaves the block as a true/complement pair. Whenever the level changes, both outputs are held low for a dead window first.

The frame sequencer is a state machine with two states. `ST_COMMA` encodes the comma and copies the payload array into a frame buffer. Its transition *comma-done* leads to `ST_DATA`. `ST_DATA` encodes one buffered byte for each refill of the holding register. After the last byte, its transition *frame-done* returns to `ST_COMMA`; until then, *next-byte* stays in `ST_DATA`. The complementary driver has two states. `DRV_RUN` drives the pair from the applied level. Its transition *level-change* leads to `DRV_DEAD`, where both outputs are low. The transition *dead-expired* returns to `DRV_RUN` after `DEAD * PRESCALE` clocks. Software changes the payload through a one-cycle write port. The reset contents are 0x01, 0x05, 0x01.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and until the first bit-period boundary, line_p is 0, line_n is 1 and underrun is 0.
- R2: A new line bit takes effect at clock edge k*T after reset release, where T = PRESCALE*PERIOD and k = 1, 2, and so on. The driver outputs follow one clock edge later.
- R3: The symbol stream is the comma K28.1 followed by payload bytes 0..NBYTES-1 in index order, repeated without gaps. With the reset payload, the first frame's code groups (abcdei fghj) are 0011111001, 1000101011, 1010010100, 0111010100.
- R4: Symbols are coded by the 5b/6b and 3b/4b 8b10b rules. Running disparity starts negative at reset and is updated after each sub-block. Every code group has 4, 5 or 6 ones.
- R5: Each code group is sent with bit a first and bit j last.
- R6: A payload write (pay_we=1, pay_idx, pay_data) that lands during a frame's comma does not alter that frame. It appears in the next frame, because the payload is captured when the comma is encoded.
- R7: A write with pay_idx >= NBYTES has no effect on the stream.
- R8: Outside a dead window, line_n equals the inverse of line_p, and line_p equals the current line bit.
- R9: When the line bit changes, both outputs are 0 for exactly DEAD*PRESCALE clocks, starting one clock after the change. When the bit repeats, no dead window is inserted.
- R10: line_p and line_n are never 1 together, and neither rises while the other was 1 in the previous cycle.
- R11: The holding register is refilled in the clock after the shifter takes it, so underrun stays 0. If the shifter ever finds it empty, underrun sets and stays set until reset, and a negative-disparity comma is sent instead.
- R12: For data D.x.7, the alternate 3b/4b code 0111/1000 is used for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity. The primary code 1110/0001 is used otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_we | input | 1 | Payload write strobe |
| pay_idx | input | IW | Payload byte index |
| pay_data | input | 8 | Payload byte value |
| line_p | output | 1 | True line output |
| line_n | output | 1 | Complement line output |
| underrun | output | 1 | Sticky flag: shifter found no symbol ready |

## Verification
Each line bit is due at clock edge k*T. The driver pair reacts one edge later: both outputs drop at edge k*T+1 and are driven again at edge k*T+DEAD*PRESCALE+1. For every bit, the bench samples on the falling clock just after edge k*T+1, just after edge k*T+DEAD*PRESCALE, and just after edge k*T+DEAD*PRESCALE+1. It compares each sample with a bit computed from its own encoder model. Payload writes are issued only while a comma is on the line. The model therefore captures the payload at the start of each frame, which is one frame before the written values become visible.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    localparam logic [7:0] K28_1_BYTE = 8'h3C;

    typedef enum logic {
        ST_COMMA = 1'b0,
        ST_DATA  = 1'b1
    } seq_state_t;

    typedef enum logic {
        DRV_RUN  = 1'b0,
        DRV_DEAD = 1'b1
    } drv_state_t;

    // Reverse a 10-bit code group so that bit a lands in bit 0.
    function automatic logic [9:0] rev10(input logic [9:0] v);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) begin
            r[i] = v[9 - i];
        end
        return r;
    endfunction

    // Reset contents of the payload array.
    function automatic logic [7:0] default_byte(input int idx);
        unique case (idx)
            0:       return 8'h01;
            1:       return 8'h05;
            2:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Comma at negative disparity, already reversed for shifting.
    localparam logic [9:0] COMMA_NEG_REV = rev10(10'b0011111001);

endpackage

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
    parameter int PRESCALE = 48,
    parameter int PERIOD   = 800
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_stb
);
    localparam int PW = $clog2(PRESCALE > 1 ? PRESCALE : 2);
    localparam int CW = $clog2(PERIOD > 1 ? PERIOD : 2);

    logic [PW-1:0] pre_q;
    logic [CW-1:0] per_q;
    logic          tick;

    assign tick    = (pre_q == PW'(PRESCALE - 1));
    assign bit_stb = tick && (per_q == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            per_q <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                per_q <= (per_q == CW'(PERIOD - 1)) ? '0 : per_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sftx_enc8b10b.sv
module sftx_enc8b10b (
    input  logic [7:0] din,
    input  logic       is_k,
    input  logic       rd_in,
    output logic [9:0] code,
    output logic       rd_out
);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] t6, c6;
    logic [3:0] t4, c4;
    logic       rd_mid;
    logic       alt7;

    always_comb begin
        x = din[4:0];
        y = din[7:5];

        // 5b/6b, listed at negative disparity
        unique case (x)
            5'd0:  t6 = 6'b100111;
            5'd1:  t6 = 6'b011101;
            5'd2:  t6 = 6'b101101;
            5'd3:  t6 = 6'b110001;
            5'd4:  t6 = 6'b110101;
            5'd5:  t6 = 6'b101001;
            5'd6:  t6 = 6'b011001;
            5'd7:  t6 = 6'b111000;
            5'd8:  t6 = 6'b111001;
            5'd9:  t6 = 6'b100101;
            5'd10: t6 = 6'b010101;
            5'd11: t6 = 6'b110100;
            5'd12: t6 = 6'b001101;
            5'd13: t6 = 6'b101100;
            5'd14: t6 = 6'b011100;
            5'd15: t6 = 6'b010111;
            5'd16: t6 = 6'b011011;
            5'd17: t6 = 6'b100011;
            5'd18: t6 = 6'b010011;
            5'd19: t6 = 6'b110010;
            5'd20: t6 = 6'b001011;
            5'd21: t6 = 6'b101010;
            5'd22: t6 = 6'b011010;
            5'd23: t6 = 6'b111010;
            5'd24: t6 = 6'b110011;
            5'd25: t6 = 6'b100110;
            5'd26: t6 = 6'b010110;
            5'd27: t6 = 6'b110110;
            5'd28: t6 = 6'b001110;
            5'd29: t6 = 6'b101110;
            5'd30: t6 = 6'b011110;
            5'd31: t6 = 6'b101011;
        endcase
        if (is_k) begin
            t6 = 6'b001111;
        end
        c6     = (rd_in && (($countones(t6) != 3) || (x == 5'd7 && !is_k))) ? ~t6 : t6;
        rd_mid = rd_in ^ ($countones(t6) != 3);

        alt7 = (y == 3'd7) && (is_k ||
               (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
               ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));

        // 3b/4b, listed at negative disparity
        unique case (y)
            3'd0: t4 = 4'b1011;
            3'd1: t4 = 4'b1001;
            3'd2: t4 = 4'b0101;
            3'd3: t4 = 4'b1100;
            3'd4: t4 = 4'b1101;
            3'd5: t4 = 4'b1010;
            3'd6: t4 = 4'b0110;
            3'd7: t4 = alt7 ? 4'b0111 : 4'b1110;
        endcase
        if (is_k && (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6)) begin
            t4 = ~t4;
        end
        c4     = (rd_mid && (($countones(t4) != 2) || y == 3'd3 || is_k)) ? ~t4 : t4;
        rd_out = rd_mid ^ ($countones(t4) != 2);
        code   = {c6, c4};
    end

endmodule

// File: rtl/sftx_frame_seq.sv
module sftx_frame_seq
    import sftx_pkg::*;
#(
    parameter int NBYTES = 3,
    localparam int IW = $clog2(NBYTES > 1 ? NBYTES : 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          pay_we,
    input  logic [IW-1:0] pay_idx,
    input  logic [7:0]    pay_data,
    output logic [9:0]    hold_q,
    output logic          hold_vld
);
    localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

    seq_state_t    st_q, st_d;
    logic [7:0]    stg_q   [NBYTES];
    logic [7:0]    frame_q [NBYTES];
    logic [IW-1:0] idx_q;
    logic          rd_q;
    logic          fill;
    logic [7:0]    enc_din;
    logic          enc_k;
    logic [9:0]    enc_code;
    logic          enc_rd;

    assign fill = !hold_vld;

    always_comb begin
        enc_k   = (st_q == ST_COMMA);
        enc_din = enc_k ? K28_1_BYTE : frame_q[idx_q];
    end

    sftx_enc8b10b u_enc (
        .din    (enc_din),
        .is_k   (enc_k),
        .rd_in  (rd_q),
        .code   (enc_code),
        .rd_out (enc_rd)
    );

    // next state: comma-done, next-byte, frame-done
    always_comb begin
        st_d = st_q;
        if (fill) begin
            unique case (st_q)
                ST_COMMA: st_d = ST_DATA;
                ST_DATA:  st_d = (idx_q == LAST) ? ST_COMMA : ST_DATA;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_COMMA;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) begin
                stg_q[i]   <= default_byte(i);
                frame_q[i] <= default_byte(i);
            end
            idx_q    <= '0;
            rd_q     <= 1'b0;
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else begin
            if (pay_we && (int'(pay_idx) < NBYTES)) begin
                stg_q[pay_idx] <= pay_data;
            end
            if (take) begin
                hold_vld <= 1'b0;
            end else if (fill) begin
                hold_q   <= rev10(enc_code);
                hold_vld <= 1'b1;
                rd_q     <= enc_rd;
                if (st_q == ST_COMMA) begin
                    frame_q <= stg_q;
                    idx_q   <= '0;
                end else begin
                    idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                end
            end
        end
    end

    AST_REFILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_vld) |=> hold_vld); // R11
    AST_GROUP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_vld) |-> ($countones(hold_q) >= 4 && $countones(hold_q) <= 6)); // R4
    AST_TAKE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_vld); // R11

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter
    import sftx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic [9:0] hold_q,
    input  logic       hold_vld,
    output logic       take,
    output logic       line_q,
    output logic       underrun
);
    logic [10:0] sreg_q;
    logic [10:0] cur;
    logic        empty;

    assign empty = (sreg_q == 11'd1);
    assign take  = bit_stb && empty && hold_vld;

    always_comb begin
        if (!empty) begin
            cur = sreg_q;
        end else if (hold_vld) begin
            cur = {1'b1, hold_q};
        end else begin
            cur = {1'b1, COMMA_NEG_REV};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q   <= 11'd1;
            line_q   <= 1'b0;
            underrun <= 1'b0;
        end else if (bit_stb) begin
            line_q <= cur[0];
            sreg_q <= {1'b0, cur[10:1]};
            if (empty && !hold_vld) begin
                underrun <= 1'b1;
            end
        end
    end

    AST_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && empty) |-> hold_vld); // R11
    AST_LINE_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(line_q)); // R2

endmodule

// File: rtl/sftx_comp_drv.sv
module sftx_comp_drv
    import sftx_pkg::*;
#(
    parameter int DW = 4800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic out_p,
    output logic out_n
);
    localparam int CNTW = $clog2(DW + 1);

    drv_state_t      st_q, st_d;
    logic            lvl_q;
    logic [CNTW-1:0] cnt_q;

    // next state: level-change, dead-expired
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DRV_RUN:  if (line_in != lvl_q) st_d = DRV_DEAD;
            DRV_DEAD: if (cnt_q == CNTW'(DW - 1)) st_d = DRV_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= DRV_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (st_q == DRV_RUN) begin
            if (line_in != lvl_q) begin
                lvl_q <= line_in;
                cnt_q <= '0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (st_q)
            DRV_RUN: begin
                out_p = lvl_q;
                out_n = !lvl_q;
            end
            DRV_DEAD: begin
                out_p = 1'b0;
                out_n = 1'b0;
            end
        endcase
    end

    AST_DEAD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DRV_RUN && line_in != lvl_q) |=> (!out_p && !out_n)); // R9
    AST_P_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_p) |-> $past(!out_n)); // R10
    AST_N_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_n) |-> $past(!out_p)); // R10

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int PRESCALE = 48,
    parameter int PERIOD   = 800,
    parameter int DEAD     = 100,
    parameter int NBYTES   = 3,
    localparam int IW = $clog2(NBYTES > 1 ? NBYTES : 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pay_we,
    input  logic [IW-1:0] pay_idx,
    input  logic [7:0]    pay_data,
    output logic          line_p,
    output logic          line_n,
    output logic          underrun
);
    localparam int DW = DEAD * PRESCALE;

    logic       bit_stb;
    logic       take;
    logic [9:0] hold_q;
    logic       hold_vld;
    logic       line_q;

    sftx_bit_timer #(
        .PRESCALE (PRESCALE),
        .PERIOD   (PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb)
    );

    sftx_frame_seq #(
        .NBYTES (NBYTES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .pay_we   (pay_we),
        .pay_idx  (pay_idx),
        .pay_data (pay_data),
        .hold_q   (hold_q),
        .hold_vld (hold_vld)
    );

    sftx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .hold_q   (hold_q),
        .hold_vld (hold_vld),
        .take     (take),
        .line_q   (line_q),
        .underrun (underrun)
    );

    sftx_comp_drv #(
        .DW (DW)
    ) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_q),
        .out_p   (line_p),
        .out_n   (line_n)
    );

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_p && line_n)); // R10

endmodule

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;
    localparam int CLK_P    = 10;
    localparam int PRESCALE = 2;
    localparam int PERIOD   = 6;
    localparam int DEAD     = 2;
    localparam int NBYTES   = 3;
    localparam int T        = PRESCALE * PERIOD;
    localparam int DW       = DEAD * PRESCALE;
    localparam int NFRAMES  = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pay_we = 1'b0;
    logic [1:0] pay_idx = '0;
    logic [7:0] pay_data = '0;
    logic       line_p, line_n, underrun;

    int n_chk = 0;
    int n_bad = 0;
    int edge_cnt = 0;
    bit done = 1'b0;
    logic [7:0] stg [NBYTES];

    always #(CLK_P / 2) clk = ~clk;

    serial_frame_tx #(
        .PRESCALE (PRESCALE),
        .PERIOD   (PERIOD),
        .DEAD     (DEAD),
        .NBYTES   (NBYTES)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pay_we   (pay_we),
        .pay_idx  (pay_idx),
        .pay_data (pay_data),
        .line_p   (line_p),
        .line_n   (line_n),
        .underrun (underrun)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edge_cnt);
        end
    endtask

    task automatic wait_to(input int target);
        while (edge_cnt < target) begin
            @(posedge clk);
            edge_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic pay_write(input logic [1:0] idx, input logic [7:0] d);
        pay_we   = 1'b1;
        pay_idx  = idx;
        pay_data = d;
        @(posedge clk);
        edge_cnt++;
        @(negedge clk);
        pay_we = 1'b0;
        if (int'(idx) < NBYTES) stg[idx] = d;
    endtask

    // Bench model of the code: returns {rd_after, abcdei, fghj}
    function automatic logic [10:0] ref_enc(input logic [7:0] b, input logic k, input logic rd);
        logic [5:0] s6;
        logic [3:0] s4;
        logic [4:0] lo;
        logic [2:0] hi;
        logic       r;
        logic       use_a7;
        lo = b[4:0];
        hi = b[7:5];
        case (lo)
            0: s6 = 6'b100111;  1: s6 = 6'b011101;  2: s6 = 6'b101101;  3: s6 = 6'b110001;
            4: s6 = 6'b110101;  5: s6 = 6'b101001;  6: s6 = 6'b011001;  7: s6 = 6'b111000;
            8: s6 = 6'b111001;  9: s6 = 6'b100101; 10: s6 = 6'b010101; 11: s6 = 6'b110100;
           12: s6 = 6'b001101; 13: s6 = 6'b101100; 14: s6 = 6'b011100; 15: s6 = 6'b010111;
           16: s6 = 6'b011011; 17: s6 = 6'b100011; 18: s6 = 6'b010011; 19: s6 = 6'b110010;
           20: s6 = 6'b001011; 21: s6 = 6'b101010; 22: s6 = 6'b011010; 23: s6 = 6'b111010;
           24: s6 = 6'b110011; 25: s6 = 6'b100110; 26: s6 = 6'b010110; 27: s6 = 6'b110110;
           28: s6 = 6'b001110; 29: s6 = 6'b101110; 30: s6 = 6'b011110; default: s6 = 6'b101011;
        endcase
        if (k) s6 = 6'b001111;
        r = rd;
        if (r == 1'b1 && (s6 != 6'b111000 || k) && $countones(s6) == 3) begin
            // balanced and not D.7 at positive disparity: unchanged
        end else if (r == 1'b1) begin
            s6 = ~s6;
        end
        if ($countones(s6) != 3) r = ~r;
        use_a7 = k || (r == 1'b0 && (lo == 17 || lo == 18 || lo == 20))
                   || (r == 1'b1 && (lo == 11 || lo == 13 || lo == 14));
        case (hi)
            0: s4 = 4'b1011; 1: s4 = k ? 4'b0110 : 4'b1001; 2: s4 = k ? 4'b1010 : 4'b0101;
            3: s4 = 4'b1100; 4: s4 = 4'b1101; 5: s4 = k ? 4'b0101 : 4'b1010;
            6: s4 = k ? 4'b1001 : 4'b0110; default: s4 = use_a7 ? 4'b0111 : 4'b1110;
        endcase
        if (r == 1'b1 && ($countones(s4) != 2 || hi == 3 || k)) s4 = ~s4;
        if ($countones(s4) != 2) r = ~r;
        return {r, s6, s4};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [9:0]  first_frame [4];
        logic [7:0]  snap [NBYTES];
        logic [7:0]  sym_b;
        logic        sym_k;
        logic [10:0] enc;
        logic [9:0]  code;
        logic        rd_m;
        logic        prev;
        logic        e;
        int          bitk;
        int          nw;
        string       tag;

        first_frame[0] = 10'b0011111001;
        first_frame[1] = 10'b1000101011;
        first_frame[2] = 10'b1010010100;
        first_frame[3] = 10'b0111010100;
        void'($urandom(32'd4021));
        for (int i = 0; i < NBYTES; i++) stg[i] = (i == 1) ? 8'h05 : 8'h01;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle state right after reset and just before the first boundary
        chk(line_p == 1'b0 && line_n == 1'b1 && underrun == 1'b0, "R1 reset",
            {29'd0, line_p, line_n, underrun}, 32'b010);
        wait_to(T - 1);
        chk(line_p == 1'b0 && line_n == 1'b1 && underrun == 1'b0, "R1 pre-first-bit",
            {29'd0, line_p, line_n, underrun}, 32'b010);

        rd_m = 1'b0;
        prev = 1'b0;
        bitk = 0;
        for (int f = 0; f < NFRAMES; f++) begin
            for (int i = 0; i < NBYTES; i++) snap[i] = stg[i];
            for (int s = 0; s <= NBYTES; s++) begin
                sym_k = (s == 0);
                sym_b = sym_k ? 8'h3C : snap[s - 1];
                enc   = ref_enc(sym_b, sym_k, rd_m);
                rd_m  = enc[10];
                code  = (f == 0) ? first_frame[s] : enc[9:0];
                if (f == 0)      tag = "R3 R5";
                else if (f == 2) tag = "R12 R6 R7 R4";
                else             tag = "R4 R5 R6 R7";
                for (int j = 0; j < 10; j++) begin
                    int base;
                    e    = code[9 - j];
                    base = (bitk + 1) * T;
                    wait_to(base + 1);
                    if (e != prev)
                        chk(!line_p && !line_n, "R9 dead start", {30'd0, line_p, line_n}, 32'b00);
                    else
                        chk(line_p == e && line_n == !e, "R9 R8 no dead on repeat",
                            {30'd0, line_p, line_n}, {30'd0, e, !e});
                    wait_to(base + DW);
                    if (e != prev)
                        chk(!line_p && !line_n, "R9 dead end", {30'd0, line_p, line_n}, 32'b00);
                    chk(!(line_p && line_n), "R10 overlap", {30'd0, line_p, line_n}, 32'b0);
                    wait_to(base + DW + 1);
                    chk(line_p == e && line_n == !e, {tag, " R2 R8 bit"},
                        {30'd0, line_p, line_n}, {30'd0, e, !e});
                    if (s == 0 && j == 3) begin
                        if (f == 1) begin
                            pay_write(2'd0, 8'hF1);
                            pay_write(2'd1, 8'hEB);
                            pay_write(2'd3, 8'hAA);
                            pay_write(2'd2, 8'hE7);
                        end else if (f == 2) begin
                            pay_write(2'd0, 8'h07);
                            pay_write(2'd1, 8'hFC);
                            pay_write(2'd2, 8'h3C);
                        end else if (f >= 3) begin
                            nw = 1 + int'($urandom % 4);
                            for (int w = 0; w < nw; w++)
                                pay_write(2'($urandom % 4), 8'($urandom % 256));
                        end
                    end
                    prev = e;
                    bitk++;
                end
            end
            chk(underrun == 1'b0, "R11 underrun", {31'd0, underrun}, 32'd0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule